// File: doc/BRIEF.md
# Power-Down Sequencer with Wake Delay

This controller puts a small processor-based system into a low-power state and brings it back out. Software sets a power-down request bit through a one-cycle pulse. The sequencer then waits a fixed grace period, measured in processor-clock cycles, so that software can halt the core. Only after that period does it assert the power-down signal. That signal drops seven active-high enables together: high-speed oscillator, PLL, reference/bias, card supply, flash read pulse, comparator and supply-fault detector. The individual enables are never cleared one by one to reach this state.

Three interrupt sources can end the power-down: external interrupt 0, the card interrupt and the keypad interrupt. They are ORed together, and a routing-select bit lets that OR through. The OR passes through a two-flop synchronizer before the sequencer acts on it. When a routed wake arrives, the sequencer does the following in order:

- It raises every enable again and clears the request bit, so the system does not re-enter power-down at once.
- It waits until the clock subsystem reports that the clock is running.
- It counts a fixed settle delay.
- It gives the core a single-cycle wake interrupt.

A routed wake that arrives during the grace period cancels the entry.

Top module: `pwrdn_sequencer`

## Requirements
- R1: A one-cycle pulse on `pd_req_set` sampled while the sequencer is idle sets `pd_req` to 1 at that clock edge.
- R2: `pd_active` rises exactly PD_DELAY_CYC (default 32) clock edges after the edge that sampled `pd_req_set`. It is low for all the edges before that.
- R3: All seven bits of `func_en` are 0 while `pd_active` is 1 and all are 1 otherwise. The bit order is [0] oscillator, [1] PLL, [2] reference/bias, [3] card supply, [4] flash read pulse, [5] comparator, [6] supply-fault detector.
- R4: Any one of `ext_int0`, `card_int` or `keypad_int`, held high with `wake_route_en` = 1 during power-down, clears `pd_active` at the third rising edge after it rises.
- R5: With `wake_route_en` = 0, the wake sources have no effect and `pd_active` stays high.
- R6: `pd_req` clears at the same edge where `pd_active` falls on a wake.
- R7: A routed wake during the grace period clears `pd_req` at the third edge after it rises. `pd_active` never asserts for that request, and no `wake_irq` follows.
- R8: After a wake, `wake_irq` stays low and the enables stay high for as long as `clk_running` is 0.
- R9: `wake_irq` rises exactly SETTLE_CYC (default 512) edges after the first edge that samples `clk_running` = 1 following a wake. It stays high for exactly one cycle.
- R10: A `pd_req_set` pulse during the wake sequence is ignored and `pd_req` stays 0. A pulse made after `wake_irq` is accepted again.
- R11: After reset, `pd_req` = 0, `pd_active` = 0, `func_en` = all ones and `wake_irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_set | input | 1 | One-cycle software write that sets the request bit |
| wake_route_en | input | 1 | Routing select: lets the ORed wake sources end power-down |
| ext_int0 | input | 1 | External interrupt 0 wake source |
| card_int | input | 1 | Card interrupt wake source |
| keypad_int | input | 1 | Keypad interrupt wake source |
| clk_running | input | 1 | Status from the clock subsystem: the clock is running |
| pd_req | output | 1 | Power-down request bit |
| pd_active | output | 1 | Power-down signal |
| func_en | output | 7 | Active-high enables of the gated functions |
| wake_irq | output | 1 | Single-cycle wake interrupt to the core |

## Verification
The bench counts edges exactly at both delays.

- It checks that `pd_active` is still low one edge before the grace period ends. A design off by one here would shorten the time software has to halt the core.
- It counts from the edge that sees `clk_running` to `wake_irq`. A counter started at the wake instead of at clock return would fire early.
- It holds a wake source high with routing disabled, then enables routing. A design that ignores the select bit wakes too early; one that latches the event wrongly never wakes.
- It raises a wake during the grace period, which must cancel the entry without an interrupt.
- It pulses the request during the settle phase, where a design that failed to block it would re-enter power-down.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PD_DELAY,
        ST_POWERED_DOWN,
        ST_CLK_WAIT,
        ST_SETTLE
    } pd_state_e;

    // Packed: first member is the MSB, so osc_en lands on bit 0.
    typedef struct packed {
        logic fault_det_en;
        logic comparator_en;
        logic flash_pulse_en;
        logic card_supply_en;
        logic ref_bias_en;
        logic pll_en;
        logic osc_en;
    } gated_en_t;

    localparam int NUM_GATED = $bits(gated_en_t);

    function automatic gated_en_t enables_for(input logic powered_down);
        gated_en_t e;
        e = '{default: !powered_down};
        return e;
    endfunction

endpackage

// File: rtl/pd_wake_sync.sv
module pd_wake_sync #(
    parameter int NUM_SRC = 3,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    output logic               wake_s
);
    logic any_src;
    logic [STAGES-1:0] chain;

    assign any_src = |src;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], any_src};
    end

    assign wake_s = chain[STAGES-1];
endmodule

// File: rtl/pd_timer.sv
module pd_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pd_ctrl_fsm.sv
module pd_ctrl_fsm
    import pwrdn_seq_pkg::*;
#(
    parameter int PD_DELAY_CYC = 32,
    parameter int SETTLE_CYC   = 512,
    parameter int CNT_W        = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_set,
    input  logic             route_en,
    input  logic             wake_s,
    input  logic             clk_running,
    input  logic [CNT_W-1:0] cnt,
    output logic             tmr_clear,
    output logic             tmr_run,
    output logic             req_bit,
    output logic             irq,
    output pd_state_e        state
);
    localparam logic [CNT_W-1:0] PD_LAST  = CNT_W'(PD_DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);

    pd_state_e nxt;
    logic      req_nxt;
    logic      irq_nxt;
    logic      wake_ok;

    assign wake_ok = wake_s && route_en;

    always_comb begin
        nxt       = state;
        req_nxt   = req_bit;
        irq_nxt   = 1'b0;
        tmr_clear = 1'b0;
        tmr_run   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (req_set) begin
                    req_nxt   = 1'b1;
                    nxt       = ST_PD_DELAY;
                    tmr_clear = 1'b1;
                end
            end
            ST_PD_DELAY: begin
                if (wake_ok) begin
                    req_nxt = 1'b0;
                    nxt     = ST_RUN;
                end else if (cnt == PD_LAST) begin
                    nxt = ST_POWERED_DOWN;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            ST_POWERED_DOWN: begin
                if (wake_ok) begin
                    req_nxt = 1'b0;
                    nxt     = ST_CLK_WAIT;
                end
            end
            ST_CLK_WAIT: begin
                if (clk_running) begin
                    nxt       = ST_SETTLE;
                    tmr_clear = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt == SET_LAST) begin
                    nxt     = ST_RUN;
                    irq_nxt = 1'b1;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            req_bit <= 1'b0;
            irq     <= 1'b0;
        end else begin
            state   <= nxt;
            req_bit <= req_nxt;
            irq     <= irq_nxt;
        end
    end
endmodule

// File: rtl/pwrdn_sequencer.sv
module pwrdn_sequencer
    import pwrdn_seq_pkg::*;
#(
    parameter int PD_DELAY_CYC = 32,
    parameter int SETTLE_CYC   = 512,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pd_req_set,
    input  logic                 wake_route_en,
    input  logic                 ext_int0,
    input  logic                 card_int,
    input  logic                 keypad_int,
    input  logic                 clk_running,
    output logic                 pd_req,
    output logic                 pd_active,
    output logic [NUM_GATED-1:0] func_en,
    output logic                 wake_irq
);
    localparam int MAX_CYC = (SETTLE_CYC > PD_DELAY_CYC) ? SETTLE_CYC : PD_DELAY_CYC;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    logic             wake_s;
    logic             tmr_clear;
    logic             tmr_run;
    logic [CNT_W-1:0] cnt;
    pd_state_e        state;
    gated_en_t        en_s;

    pd_wake_sync #(.NUM_SRC(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .src    ({keypad_int, card_int, ext_int0}),
        .wake_s (wake_s)
    );

    pd_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .run   (tmr_run),
        .cnt   (cnt)
    );

    pd_ctrl_fsm #(
        .PD_DELAY_CYC (PD_DELAY_CYC),
        .SETTLE_CYC   (SETTLE_CYC),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_set     (pd_req_set),
        .route_en    (wake_route_en),
        .wake_s      (wake_s),
        .clk_running (clk_running),
        .cnt         (cnt),
        .tmr_clear   (tmr_clear),
        .tmr_run     (tmr_run),
        .req_bit     (pd_req),
        .irq         (wake_irq),
        .state       (state)
    );

    assign pd_active = (state == ST_POWERED_DOWN);
    assign en_s      = enables_for(pd_active);
    assign func_en   = en_s;
endmodule

// File: rtl/pwrdn_sequencer_chk.sv
module pwrdn_sequencer_chk #(
    parameter int PD_DELAY_CYC = 32,
    parameter int NUM_GATED    = 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wake_route_en,
    input logic                 pd_req,
    input logic                 pd_active,
    input logic [NUM_GATED-1:0] func_en,
    input logic                 wake_irq
);
    int unsigned req_hold;

    always_ff @(posedge clk) begin
        if (rst || !pd_req)  req_hold <= 0;
        else if (!pd_active) req_hold <= req_hold + 1;
    end

    assert_entry_delay_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_active) |-> (req_hold == PD_DELAY_CYC));

    assert_enables_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (pd_active ? (func_en == '0) : (func_en == '1)));

    assert_no_route_no_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (pd_active && !wake_route_en) |=> pd_active);

    assert_req_clears_on_wake_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_active) |-> !pd_req);

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> !wake_irq);

    assert_irq_when_up_R9: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> (!pd_active && !pd_req));
endmodule

bind pwrdn_sequencer pwrdn_sequencer_chk #(
    .PD_DELAY_CYC (PD_DELAY_CYC),
    .NUM_GATED    (pwrdn_seq_pkg::NUM_GATED)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wake_route_en (wake_route_en),
    .pd_req        (pd_req),
    .pd_active     (pd_active),
    .func_en       (func_en),
    .wake_irq      (wake_irq)
);

// File: tb/pwrdn_sequencer_tb_top.sv
module pwrdn_sequencer_tb_top;
    localparam int PD_CYC  = 32;
    localparam int SET_CYC = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_req_set = 1'b0, wake_route_en = 1'b1;
    logic ext_int0 = 1'b0, card_int = 1'b0, keypad_int = 1'b0, clk_running = 1'b1;
    logic pd_req, pd_active, wake_irq;
    logic [6:0] func_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwrdn_sequencer dut_i (
        .clk(clk), .rst(rst), .pd_req_set(pd_req_set), .wake_route_en(wake_route_en),
        .ext_int0(ext_int0), .card_int(card_int), .keypad_int(keypad_int),
        .clk_running(clk_running), .pd_req(pd_req), .pd_active(pd_active),
        .func_en(func_en), .wake_irq(wake_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nedge(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Request power-down and verify the grace period and gating (R1, R2, R3).
    task automatic enter_pd();
        @(negedge clk);
        pd_req_set = 1'b1;
        @(negedge clk);
        pd_req_set = 1'b0;
        check("R1 pd_req set", pd_req, 1'b1);
        nedge(PD_CYC - 1);
        check("R2 pd_active low one edge early", pd_active, 1'b0);
        check("R3 enables on before entry", func_en, 7'h7f);
        nedge(1);
        check("R2 pd_active at delay", pd_active, 1'b1);
        check("R3 enables off", func_en, 7'h00);
    endtask

    // Count edges until wake_irq; expect it after exactly n edges, one cycle wide (R9).
    task automatic expect_irq_after(input string req, input int n);
        int seen = 0;
        for (int i = 1; i <= n + 4; i++) begin
            @(negedge clk);
            if (wake_irq && seen == 0) seen = i;
        end
        check(req, seen, n);
    endtask

    task automatic t_reset();
        check("R11 pd_req", pd_req, 1'b0);
        check("R11 pd_active", pd_active, 1'b0);
        check("R11 func_en", func_en, 7'h7f);
        check("R11 wake_irq", wake_irq, 1'b0);
    endtask

    task automatic t_full_cycle_slow_clock();
        enter_pd();
        clk_running = 1'b0;
        nedge(5);
        ext_int0 = 1'b1;
        nedge(2);
        check("R4 still down after two edges", pd_active, 1'b1);
        nedge(1);
        check("R4 ext_int0 wakes", pd_active, 1'b0);
        check("R6 pd_req cleared", pd_req, 1'b0);
        check("R3 enables restored", func_en, 7'h7f);
        ext_int0 = 1'b0;
        begin
            int irq_seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (wake_irq) irq_seen++;
            end
            check("R8 no irq while clock stopped", irq_seen, 0);
        end
        clk_running = 1'b1;
        expect_irq_after("R9 settle count from clock return", SET_CYC + 1);
    endtask

    task automatic t_unrouted();
        wake_route_en = 1'b0;
        enter_pd();
        card_int = 1'b1;
        nedge(10);
        check("R5 unrouted card_int ignored", pd_active, 1'b1);
        wake_route_en = 1'b1;
        nedge(1);
        check("R4 card_int wakes once routed", pd_active, 1'b0);
        card_int = 1'b0;
        expect_irq_after("R9 irq after routed card wake", SET_CYC + 1);
    endtask

    task automatic t_keypad();
        enter_pd();
        keypad_int = 1'b1;
        nedge(3);
        check("R4 keypad_int wakes", pd_active, 1'b0);
        keypad_int = 1'b0;
        // CLK_WAIT entered at this edge; clk_running sampled at the next one.
        expect_irq_after("R9 irq with clock already running", SET_CYC + 1);
    endtask

    task automatic t_cancel();
        @(negedge clk);
        pd_req_set = 1'b1;
        @(negedge clk);
        pd_req_set = 1'b0;
        nedge(10);
        ext_int0 = 1'b1;
        nedge(3);
        check("R7 request cancelled", pd_req, 1'b0);
        ext_int0 = 1'b0;
        begin
            int pd_seen = 0, irq_seen = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (pd_active) pd_seen++;
                if (wake_irq) irq_seen++;
            end
            check("R7 pd_active never asserted", pd_seen, 0);
            check("R7 no wake_irq", irq_seen, 0);
        end
    endtask

    task automatic t_req_during_settle();
        enter_pd();
        ext_int0 = 1'b1;
        nedge(3);
        ext_int0 = 1'b0;
        nedge(50);
        pd_req_set = 1'b1;
        @(negedge clk);
        pd_req_set = 1'b0;
        check("R10 request ignored in settle", pd_req, 1'b0);
        expect_irq_after("R9 irq unaffected by ignored request", SET_CYC + 1 - 51);
        @(negedge clk);
        pd_req_set = 1'b1;
        @(negedge clk);
        pd_req_set = 1'b0;
        check("R10 request accepted after irq", pd_req, 1'b1);
        nedge(PD_CYC);
        check("R2 re-entry reaches power-down", pd_active, 1'b1);
        ext_int0 = 1'b1;
        nedge(3);
        ext_int0 = 1'b0;
        nedge(SET_CYC + 4);
    endtask

    initial begin
        nedge(3);
        rst = 1'b0;
        nedge(1);
        t_reset();
        t_full_cycle_slow_clock();
        t_unrouted();
        t_keypad();
        t_cancel();
        t_req_during_settle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule